// File: doc/BRIEF.md
# CRC-4 Error Tally and False-Alignment Judge

This block sits behind the CRC-4 checker of an E1 receiver. Each time a submultiframe finishes, the checker raises a one-cycle strobe together with a flag that says whether the received CRC-4 bits disagreed with the locally computed remainder. The block keeps a 16-bit count of these disagreements while the receiver holds multiframe alignment. Software can clear the count with a strobe. When enabled, the block also pulses an interrupt for each error it counts.

With automatic resynchronization switched on, the block also judges the quality of the alignment. It groups submultiframes into consecutive blocks of 1000. If 915 of them within one block carry a CRC error, it treats the alignment as false. It then pulses a request that tells the frame and multiframe aligners to start a new search from just after the last basic frame alignment signal. Leaving multiframe sync, or switching the feature off, empties the judgement counters, so each fresh alignment starts a clean assessment.

Top module: `crc4_mon`

## Requirements
- R1: While `mf_sync`=1, a `smf_done` strobe with `smf_crc_bad`=1 raises `err_count` by exactly one on the following clock edge. A strobe with `smf_crc_bad`=0 leaves it unchanged.
- R2: While `mf_sync`=0, strobes leave `err_count` unchanged and produce no interrupt.
- R3: `err_count` saturates at 65535 (all ones) and stays there on further errors.
- R4: `cnt_clr`=1 sets `err_count` to 0 on the next edge. If a counted error arrives in the same cycle, the value becomes 1.
- R5: `crc_irq` is a one-cycle pulse in the cycle after each counted error while `irq_en`=1. It never rises while `irq_en`=0.
- R6: With `auto_resync_en`=1 and `mf_sync`=1, `resync_req` pulses for one cycle in the cycle after the strobe that brings the errored-submultiframe tally of the current block to 915.
- R7: A judgement block ends after its 1000th strobe, and both the submultiframe and error tallies return to zero then. Errors from two different blocks never add up to a trip.
- R8: While `auto_resync_en`=0, the tallies are held at zero and `resync_req` stays low. After the feature is enabled, a trip needs 915 fresh errors.
- R9: Any cycle with `mf_sync`=0 empties the tallies, so the assessment restarts from zero when sync is regained.
- R10: After a trip the tallies restart from zero. A further 915 errors are needed before another request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smf_done | input | 1 | One-cycle strobe at the end of each submultiframe |
| smf_crc_bad | input | 1 | CRC-4 mismatch for the submultiframe flagged by `smf_done` |
| mf_sync | input | 1 | Receiver is in multiframe-synchronous state |
| auto_resync_en | input | 1 | Enables the 915-of-1000 false-alignment judge |
| irq_en | input | 1 | Enables the per-error interrupt pulse |
| cnt_clr | input | 1 | Clears the error count (read-and-clear strobe) |
| err_count | output | 16 | Saturating count of CRC-4 errors |
| crc_irq | output | 1 | One-cycle pulse per counted error |
| resync_req | output | 1 | One-cycle request for a new frame and multiframe search |

## Verification
The hardest situation to reach from the ports is a trip that lands exactly on the 915th error of a block. It has to be told apart from error runs that straddle a block boundary, a loss of sync or a disabled period. The stimulus sends long runs of back-to-back strobes with measured mixes of good and bad submultiframes. One example is 85 good, then 914 bad, then 1 good, which closes a block one error short. The bench watches `resync_req` after every single strobe so that an early or late trip is caught at the offending submultiframe. Saturation is reached the same way, by streaming 65535 counted errors with the judge disabled.

// File: rtl/crc4_mon_pkg.sv
package crc4_mon_pkg;

    localparam int unsigned CNT_W_DEF   = 16;
    localparam int unsigned WIN_LEN_DEF = 1000;
    localparam int unsigned WIN_THR_DEF = 915;

    // One submultiframe report from the CRC checker
    typedef struct packed {
        logic strobe;
        logic crc_bad;
        logic in_sync;
    } smf_evt_t;

    // What the judgement window does on a given cycle
    typedef enum logic [2:0] {
        WACT_CLEAR,
        WACT_KEEP,
        WACT_STEP,
        WACT_END,
        WACT_TRIP
    } win_act_t;

    function automatic logic evt_counts(input smf_evt_t e);
        return e.strobe & e.crc_bad & e.in_sync;
    endfunction

    function automatic logic evt_steps(input smf_evt_t e);
        return e.strobe & e.in_sync;
    endfunction

endpackage

// File: rtl/crc4_err_tally.sv
module crc4_err_tally #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         count_en,
    input  logic         clr,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (clr) begin
            value <= count_en ? ONE : '0;
        end else if (count_en && (value != MAXV)) begin
            value <= value + ONE;
        end
    end
endmodule

// File: rtl/crc4_judge_window.sv
module crc4_judge_window
    import crc4_mon_pkg::*;
#(
    parameter int unsigned LEN = 1000,
    parameter int unsigned THR = 915
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic smf_step,
    input  logic err_step,
    output logic trip
);
    localparam int unsigned SMF_W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam int unsigned ERR_W = $clog2(THR + 1);
    localparam logic [SMF_W-1:0] SMF_LAST = SMF_W'(LEN - 1);
    localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(THR - 1);

    logic [SMF_W-1:0] smf_cnt;
    logic [ERR_W-1:0] err_cnt;
    win_act_t         act;

    always_comb begin
        if (!enable)
            act = WACT_CLEAR;
        else if (!smf_step)
            act = WACT_KEEP;
        else if (err_step && (err_cnt == ERR_LAST))
            act = WACT_TRIP;
        else if (smf_cnt == SMF_LAST)
            act = WACT_END;
        else
            act = WACT_STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smf_cnt <= '0;
            err_cnt <= '0;
            trip    <= 1'b0;
        end else begin
            trip <= (act == WACT_TRIP);
            unique case (act)
                WACT_STEP: begin
                    smf_cnt <= smf_cnt + SMF_W'(1);
                    err_cnt <= err_cnt + ERR_W'(err_step);
                end
                WACT_KEEP: begin
                    smf_cnt <= smf_cnt;
                    err_cnt <= err_cnt;
                end
                default: begin
                    smf_cnt <= '0;
                    err_cnt <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/crc4_mon.sv
module crc4_mon
    import crc4_mon_pkg::*;
#(
    parameter int unsigned CNT_W   = CNT_W_DEF,
    parameter int unsigned WIN_LEN = WIN_LEN_DEF,
    parameter int unsigned WIN_THR = WIN_THR_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smf_done,
    input  logic             smf_crc_bad,
    input  logic             mf_sync,
    input  logic             auto_resync_en,
    input  logic             irq_en,
    input  logic             cnt_clr,
    output logic [CNT_W-1:0] err_count,
    output logic             crc_irq,
    output logic             resync_req
);
    smf_evt_t evt;
    logic     counted;
    logic     stepped;

    always_comb begin
        evt.strobe  = smf_done;
        evt.crc_bad = smf_crc_bad;
        evt.in_sync = mf_sync;
        counted     = evt_counts(evt);
        stepped     = evt_steps(evt);
    end

    crc4_err_tally #(.W(CNT_W)) i_tally (
        .clk      (clk),
        .rst      (rst),
        .count_en (counted),
        .clr      (cnt_clr),
        .value    (err_count)
    );

    crc4_judge_window #(.LEN(WIN_LEN), .THR(WIN_THR)) i_judge (
        .clk      (clk),
        .rst      (rst),
        .enable   (auto_resync_en & mf_sync),
        .smf_step (stepped),
        .err_step (counted),
        .trip     (resync_req)
    );

    always_ff @(posedge clk) begin
        if (rst) crc_irq <= 1'b0;
        else     crc_irq <= irq_en & counted;
    end
endmodule

// File: rtl/crc4_mon_chk.sv
module crc4_mon_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             smf_done,
    input logic             smf_crc_bad,
    input logic             mf_sync,
    input logic             auto_resync_en,
    input logic             irq_en,
    input logic             cnt_clr,
    input logic [CNT_W-1:0] err_count,
    input logic             crc_irq,
    input logic             resync_req
);
    localparam logic [CNT_W-1:0] MAXV = '1;
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R1
    step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(cnt_clr)) |->
        (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));

    // R2
    hold_out_of_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(mf_sync) && !$past(cnt_clr)) |-> $stable(err_count));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(err_count) == MAXV && !$past(cnt_clr)) |-> err_count == MAXV);

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && crc_irq) |->
        ($past(irq_en) && $past(smf_done) && $past(smf_crc_bad) && $past(mf_sync)));

    // R6
    req_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && resync_req) |->
        ($past(auto_resync_en) && $past(mf_sync) && $past(smf_done) && $past(smf_crc_bad)));

    // R10
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        resync_req |=> !resync_req);
endmodule

bind crc4_mon crc4_mon_chk #(.CNT_W(CNT_W)) i_chk (
    .clk            (clk),
    .rst            (rst),
    .smf_done       (smf_done),
    .smf_crc_bad    (smf_crc_bad),
    .mf_sync        (mf_sync),
    .auto_resync_en (auto_resync_en),
    .irq_en         (irq_en),
    .cnt_clr        (cnt_clr),
    .err_count      (err_count),
    .crc_irq        (crc_irq),
    .resync_req     (resync_req)
);

// File: tb/test_crc4_mon.sv
module test_crc4_mon;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smf_done = 1'b0;
    logic        smf_crc_bad = 1'b0;
    logic        mf_sync = 1'b0;
    logic        auto_resync_en = 1'b0;
    logic        irq_en = 1'b0;
    logic        cnt_clr = 1'b0;
    logic [15:0] err_count;
    logic        crc_irq;
    logic        resync_req;

    int n_chk = 0;
    int n_bad = 0;
    int fired = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    crc4_mon i_crc4_mon (
        .clk(clk), .rst(rst), .smf_done(smf_done), .smf_crc_bad(smf_crc_bad),
        .mf_sync(mf_sync), .auto_resync_en(auto_resync_en), .irq_en(irq_en),
        .cnt_clr(cnt_clr), .err_count(err_count), .crc_irq(crc_irq),
        .resync_req(resync_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one submultiframe; returns at the negedge where its results are visible
    task automatic smf(input logic bad);
        @(negedge clk);
        smf_done = 1'b1;
        smf_crc_bad = bad;
        @(negedge clk);
        smf_done = 1'b0;
        smf_crc_bad = 1'b0;
        if (resync_req) fired++;
    endtask

    task automatic run(input int n, input logic bad);
        for (int i = 0; i < n; i++) smf(bad);
    endtask

    task automatic clear_count();
        @(negedge clk); cnt_clr = 1'b1;
        @(negedge clk); cnt_clr = 1'b0;
    endtask

    task automatic win_restart();
        @(negedge clk); auto_resync_en = 1'b0;
        @(negedge clk); auto_resync_en = 1'b1;
        fired = 0;
    endtask

    task automatic t_reset();
        check("R1 reset count", err_count, 0);
        check("R5 reset irq", crc_irq, 0);
        check("R6 reset req", resync_req, 0);
    endtask

    task automatic t_count();
        mf_sync = 1'b1; irq_en = 1'b1;
        smf(1'b1); check("R1 first error", err_count, 1); check("R5 irq pulse", crc_irq, 1);
        smf(1'b0); check("R1 good smf", err_count, 1); check("R5 no irq on good", crc_irq, 0);
        smf(1'b1); smf(1'b1); check("R1 three errors", err_count, 3);
        @(negedge clk); check("R5 irq one cycle", crc_irq, 0);
    endtask

    task automatic t_nosync();
        int irqs = 0;
        mf_sync = 1'b0;
        for (int i = 0; i < 3; i++) begin smf(1'b1); if (crc_irq) irqs++; end
        check("R2 count held", err_count, 3);
        check("R2 no irq", irqs, 0);
        mf_sync = 1'b1;
    endtask

    task automatic t_irq_off();
        irq_en = 1'b0;
        smf(1'b1);
        check("R5 irq masked", crc_irq, 0);
        check("R1 counted while masked", err_count, 4);
    endtask

    task automatic t_clear();
        clear_count();
        check("R4 cleared", err_count, 0);
        @(negedge clk); cnt_clr = 1'b1; smf_done = 1'b1; smf_crc_bad = 1'b1;
        @(negedge clk); cnt_clr = 1'b0; smf_done = 1'b0; smf_crc_bad = 1'b0;
        check("R4 clear with error", err_count, 1);
    endtask

    task automatic t_sat();
        auto_resync_en = 1'b0;
        clear_count();
        run(65535, 1'b1);
        check("R3 reach max", err_count, 65535);
        smf(1'b1);
        check("R3 saturated", err_count, 65535);
        clear_count();
    endtask

    task automatic t_trip();
        win_restart();
        run(914, 1'b1);
        check("R6 no trip at 914", fired, 0);
        smf(1'b1);
        check("R6 trip at 915", resync_req, 1);
        check("R6 single trip", fired, 1);
        @(negedge clk);
        check("R6 pulse one cycle", resync_req, 0);
        run(10, 1'b1);
        check("R10 restart after trip", fired, 1);
    endtask

    task automatic t_block();
        win_restart();
        run(85, 1'b0); run(914, 1'b1); run(1, 1'b0);
        check("R7 block one short", fired, 0);
        smf(1'b1);
        check("R7 new block fresh", fired, 0);
        run(913, 1'b1);
        check("R7 914 in block", fired, 0);
        smf(1'b1);
        check("R7 trip in new block", fired, 1);
    endtask

    task automatic t_auto_off();
        @(negedge clk); auto_resync_en = 1'b0; fired = 0;
        run(920, 1'b1);
        check("R8 disabled no req", fired, 0);
        auto_resync_en = 1'b1;
        run(914, 1'b1);
        check("R8 fresh after enable", fired, 0);
        smf(1'b1);
        check("R8 trip after enable", fired, 1);
    endtask

    task automatic t_sync_loss();
        win_restart();
        run(914, 1'b1);
        @(negedge clk); mf_sync = 1'b0;
        @(negedge clk); mf_sync = 1'b1;
        smf(1'b1);
        check("R9 cleared on sync loss", fired, 0);
        run(913, 1'b1);
        check("R9 914 after regain", fired, 0);
        smf(1'b1);
        check("R9 trip after regain", fired, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_count();
        t_nosync();
        t_irq_off();
        t_clear();
        t_sat();
        t_trip();
        t_block();
        t_auto_off();
        t_sync_loss();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule